// File: doc/BRIEF.md
# Processor Data Store with Constant Table and I/O Register

This block is the whole 32-location, 8-bit data space of a small accumulator processor with a 5-bit address. One address space holds three kinds of storage. The lowest fourteen locations are ordinary read/write memory, used for both program and data. The next location is an I/O register: its low bit shows an external input pin, and its upper seven bits drive seven output pins. The remaining locations form a read-only table. This table holds a pointer, ten seven-segment digit patterns, one zero entry and a run of ones.

The processor reads through a combinational path and writes on the rising clock edge. A scan controller can replace all writable state in one cycle through a wide parallel load port. It can watch the same state at all times on a matching observe port.

Top module: `mem_io_store`

## Requirements
- R1: With `wr_en` high and `addr` in 0..13, `wr_data` is stored at that address on the rising edge. Reading an address in 0..13 returns its stored byte combinationally, in the same cycle.
- R2: Reading address 14 returns `{pin_out, pin_in}`. Bit 0 follows `pin_in` combinationally, with no clock edge in between.
- R3: A write to address 14 puts `wr_data[7:1]` onto `pin_out[6:0]` at the rising edge. `wr_data[0]` is discarded.
- R4: Address 15 reads as 16, which is the address of the pattern for digit 0.
- R5: Addresses 16..25 read as the seven-segment patterns for digits 0..9 in order. Bit 0 is segment a and bit 6 is segment g, and bit 7 is 0. The values are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R6: Address 26 reads as 0, and addresses 27..31 read as 1.
- R7: Writes to addresses 15..31 change no stored byte and no output pin.
- R8: A synchronous, active-high `rst` clears all fourteen memory bytes and `pin_out` to zero. It takes priority over every other input.
- R9: With `scan_load` high, the rising edge loads every writable bit from `scan_image_in`. Byte k is at bits [8k+7:8k], and the seven I/O output bits are at [118:112]. A CPU write in the same cycle is dropped.
- R10: `scan_image_out` shows the current writable state at all times, in the layout of R9.
- R11: With `wr_en`, `scan_load` and `rst` all low, no writable state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 5 | Read/write address |
| wr_en | input | 1 | Write strobe for the CPU |
| wr_data | input | 8 | Write data from the CPU |
| rd_data | output | 8 | Combinational read data |
| pin_in | input | 1 | External input pin, shown at address 14 bit 0 |
| pin_out | output | 7 | Output pins, driven from address 14 bits 7..1 |
| scan_load | input | 1 | Parallel load of all writable state |
| scan_image_in | input | 119 | Image loaded when `scan_load` is high |
| scan_image_out | output | 119 | Live image of all writable state |

## Verification
The bench aims at the boundaries between the three storage regions. A decoder that is off by one would let address 14 alias memory byte 13, or address 15 alias the I/O register. It would also shift the digit table by one, or return a pattern or a one at address 26. The bench writes to constant addresses and then checks the full observe image. A design that did not block those writes would corrupt a memory byte or toggle pins. The bench writes bytes with bit 0 set to the I/O register and toggles the input pin. This catches a register that latches the pin or stores `wr_data[0]`. It also loads a scan image in the same cycle as a CPU write, and asserts reset in the middle of traffic. A wrong priority order shows up as one stale byte.

// File: rtl/mem_io_store_pkg.sv
package mem_io_store_pkg;

    localparam int DIGITS = 10;

    // Seven-segment pattern, bit 0 = segment a ... bit 6 = segment g.
    function automatic logic [7:0] seg_pattern(input logic [3:0] digit);
        logic [7:0] p;
        case (digit)
            4'd0:    p = 8'h3F;
            4'd1:    p = 8'h06;
            4'd2:    p = 8'h5B;
            4'd3:    p = 8'h4F;
            4'd4:    p = 8'h66;
            4'd5:    p = 8'h6D;
            4'd6:    p = 8'h7D;
            4'd7:    p = 8'h07;
            4'd8:    p = 8'h7F;
            4'd9:    p = 8'h6F;
            default: p = 8'h00;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/gp_ram.sv
module gp_ram #(
    parameter int WORDS  = 14,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         load_en,
    input  logic [WORDS-1:0][DATA_W-1:0] load_words,
    output logic [WORDS-1:0][DATA_W-1:0] words
);

    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(WORDS);

    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] mem;
    } ram_st_t;

    ram_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.mem = load_words;
        end else if (wr_en && (addr < LIMIT)) begin
            for (int k = 0; k < WORDS; k++) begin
                if (addr == ADDR_W'(k)) begin
                    st_d.mem[k] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words = st_q.mem;

    p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !load_en && (addr < LIMIT)) |=> (words[$past(addr)] == $past(wr_data)));

    p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (words == $past(load_words)));

    p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (words == '0));

endmodule

// File: rtl/io_port.sv
module io_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_wr,
    input  logic [DATA_W-2:0] wr_bits,
    input  logic              load_en,
    input  logic [DATA_W-2:0] load_bits,
    output logic [DATA_W-2:0] out_bits
);

    typedef struct packed {
        logic [DATA_W-2:0] outs;
    } io_st_t;

    io_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.outs = load_bits;
        end else if (sel_wr) begin
            st_d.outs = wr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_bits = st_q.outs;

    p_io_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!sel_wr && !load_en) |=> $stable(out_bits));

    p_io_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_bits == '0));

endmodule

// File: rtl/const_rom.sv
module const_rom #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 5,
    parameter int PTR_ADDR = 15
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    import mem_io_store_pkg::*;

    localparam logic [ADDR_W-1:0] PTR_A  = ADDR_W'(PTR_ADDR);
    localparam logic [ADDR_W-1:0] SEG_A  = ADDR_W'(PTR_ADDR + 1);
    localparam logic [ADDR_W-1:0] GAP_A  = ADDR_W'(PTR_ADDR + 1 + DIGITS);

    always_comb begin
        if (addr == PTR_A) begin
            data = DATA_W'(PTR_ADDR + 1);
        end else if ((addr >= SEG_A) && (addr < GAP_A)) begin
            data = DATA_W'(seg_pattern(4'(addr - SEG_A)));
        end else if (addr == GAP_A) begin
            data = '0;
        end else begin
            data = DATA_W'(1);
        end
    end

endmodule

// File: rtl/mem_io_store.sv
module mem_io_store #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 5,
    parameter int RAM_WORDS = 14
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [ADDR_W-1:0]                        addr,
    input  logic                                     wr_en,
    input  logic [DATA_W-1:0]                        wr_data,
    output logic [DATA_W-1:0]                        rd_data,
    input  logic                                     pin_in,
    output logic [DATA_W-2:0]                        pin_out,
    input  logic                                     scan_load,
    input  logic [RAM_WORDS*DATA_W+DATA_W-2:0]       scan_image_in,
    output logic [RAM_WORDS*DATA_W+DATA_W-2:0]       scan_image_out
);

    localparam int RAM_BITS = RAM_WORDS * DATA_W;
    localparam logic [ADDR_W-1:0] IO_A  = ADDR_W'(RAM_WORDS);
    localparam logic [ADDR_W-1:0] PTR_A = ADDR_W'(RAM_WORDS + 1);

    logic [RAM_WORDS-1:0][DATA_W-1:0] ram_words;
    logic [DATA_W-2:0]                io_bits;
    logic [DATA_W-1:0]                rom_data;
    logic                             io_wr;

    assign io_wr = wr_en && (addr == IO_A);

    gp_ram #(
        .WORDS (RAM_WORDS),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_ram (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .load_en   (scan_load),
        .load_words(scan_image_in[RAM_BITS-1:0]),
        .words     (ram_words)
    );

    io_port #(
        .DATA_W(DATA_W)
    ) u_io (
        .clk      (clk),
        .rst      (rst),
        .sel_wr   (io_wr),
        .wr_bits  (wr_data[DATA_W-1:1]),
        .load_en  (scan_load),
        .load_bits(scan_image_in[RAM_BITS +: DATA_W-1]),
        .out_bits (io_bits)
    );

    const_rom #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .PTR_ADDR(RAM_WORDS + 1)
    ) u_rom (
        .addr(addr),
        .data(rom_data)
    );

    always_comb begin
        rd_data = rom_data;
        if (addr < IO_A) begin
            rd_data = ram_words[addr];
        end else if (addr == IO_A) begin
            rd_data = {io_bits, pin_in};
        end
    end

    assign pin_out        = io_bits;
    assign scan_image_out = {io_bits, ram_words};

    p_const_write_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !scan_load && (addr >= PTR_A)) |=> $stable(scan_image_out));

    p_const_stable_r4: assert property (@(posedge clk) disable iff (rst)
        ((addr >= PTR_A) && $past(addr) == addr && !$past(rst)) |-> (rd_data == $past(rd_data)));

endmodule

// File: tb/tb_mem_io_store.sv
module tb_mem_io_store;

    localparam int IMG_W = 119;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [4:0]       addr = '0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic [7:0]       rd_data;
    logic             pin_in = 1'b0;
    logic [6:0]       pin_out;
    logic             scan_load = 1'b0;
    logic [IMG_W-1:0] scan_image_in = '0;
    logic [IMG_W-1:0] scan_image_out;

    logic [7:0] m_ram [14];
    logic [6:0] m_io;
    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mem_io_store dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .scan_load(scan_load), .scan_image_in(scan_image_in),
        .scan_image_out(scan_image_out)
    );

    function automatic logic [7:0] seg_of(input int d);
        logic [7:0] t [10] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66,
                               8'h6D, 8'h7D, 8'h07, 8'h7F, 8'h6F};
        return t[d];
    endfunction

    function automatic logic [7:0] exp_read(input int a, input logic pin);
        if (a < 14)  return m_ram[a];
        if (a == 14) return {m_io, pin};
        if (a == 15) return 8'd16;
        if (a < 26)  return seg_of(a - 16);
        if (a == 26) return 8'd0;
        return 8'd1;
    endfunction

    function automatic string tag_of(input int a);
        if (a < 14)  return "R1";
        if (a == 14) return "R2";
        if (a == 15) return "R4";
        if (a < 26)  return "R5";
        return "R6";
    endfunction

    function automatic logic [IMG_W-1:0] exp_image();
        logic [IMG_W-1:0] v;
        for (int k = 0; k < 14; k++) v[k*8 +: 8] = m_ram[k];
        v[112 +: 7] = m_io;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [IMG_W-1:0] act, input logic [IMG_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the combinational read and the
    // state image before the rising edge, then advance the reference model.
    task automatic step(input logic r, input int a, input logic we, input logic [7:0] wd,
                        input logic pin, input logic ld, input logic [IMG_W-1:0] img,
                        input string stag);
        @(negedge clk);
        rst = r; addr = 5'(a); wr_en = we; wr_data = wd; pin_in = pin;
        scan_load = ld; scan_image_in = img;
        #1;
        chk(tag_of(a), IMG_W'(rd_data), IMG_W'(exp_read(a, pin)));
        chk(stag, scan_image_out, exp_image());
        chk({stag, " R3"}, IMG_W'(pin_out), IMG_W'(m_io));
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < 14; k++) m_ram[k] = '0;
            m_io = '0;
        end else if (ld) begin
            for (int k = 0; k < 14; k++) m_ram[k] = img[k*8 +: 8];
            m_io = img[112 +: 7];
        end else if (we) begin
            if (a < 14) m_ram[a] = wd;
            else if (a == 14) m_io = wd[7:1];
        end
    endtask

    function automatic logic [IMG_W-1:0] rand_img();
        logic [IMG_W-1:0] v;
        for (int k = 0; k < 4; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < 14; k++) m_ram[k] = '0;
        m_io = '0;
        // R8: reset state
        step(1, 0, 0, 0, 0, 0, '0, "R8");
        step(0, 0, 0, 0, 0, 0, '0, "R8");
        // R4 R5 R6: constant sweep
        for (int a = 15; a < 32; a++) step(0, a, 0, 0, 0, 0, '0, "R6");
        // R1: fill memory
        for (int a = 0; a < 14; a++) step(0, a, 1, 8'(a * 17 + 3), 0, 0, '0, "R1");
        // R3: write I/O with bit 0 set, pin_out should become 7'h52
        step(0, 14, 1, 8'hA5, 0, 0, '0, "R3");
        step(0, 14, 0, 0, 1, 0, '0, "R3");
        chk("R3 direct", IMG_W'(pin_out), IMG_W'(7'h52));
        // R2: toggle pin with address 14 held
        step(0, 14, 0, 0, 0, 0, '0, "R2");
        step(0, 14, 0, 0, 1, 0, '0, "R2");
        // R7: writes to every constant address
        for (int a = 15; a < 32; a++) step(0, a, 1, 8'hFF, 1, 0, '0, "R7");
        step(0, 20, 0, 0, 0, 0, '0, "R7");
        // R9: load and CPU write in the same cycle
        step(0, 5, 1, 8'hEE, 0, 1, rand_img(), "R9");
        step(0, 14, 1, 8'h01, 0, 1, rand_img(), "R9");
        step(0, 5, 0, 0, 0, 0, '0, "R9");
        // R11: wr_en low with data present
        step(0, 3, 0, 8'h99, 0, 0, '0, "R11");
        step(0, 3, 0, 8'h99, 0, 0, '0, "R11");
        // R8: reset during a write and load
        step(1, 2, 1, 8'h44, 0, 1, rand_img(), "R8");
        step(0, 2, 0, 0, 0, 0, '0, "R8");
        // Random traffic, R10 image tracked every cycle
        for (int i = 0; i < 3000; i++) begin
            int a = int'($urandom_range(31, 0));
            logic we = $urandom_range(1, 0) == 1;
            logic ld = $urandom_range(63, 0) == 0;
            logic r  = $urandom_range(399, 0) == 0;
            step(r, a, we, 8'($urandom), 1'($urandom), ld, rand_img(), "R10");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule